// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two data buses, called A and B, through a set of independent sections. Each section is WIDTH bits wide (nine by default). In each section, one control bit isolates both buses and a direction bit chooses which bus is driven. A source select for each direction picks what the driven bus receives: either the live value on the opposite bus or a value held in a storage register. Each direction has its own storage register, loaded by its own capture strobe. Loading never depends on whether a bus is driven. Two sections can run independently, or can be driven with identical controls to form one path of twice the width.

Each bus port is modelled as an input value, an output value and a drive flag, so the block needs no tri-state nets. A pad wrapper can merge the three into a bidirectional pin. When a port drives, its own input carries the driven value, and a capture on that side stores that value. The capture strobes are sampled on the block clock. A strobe that is high at a clock edge, after being low at the edge before, loads its register on that edge.

Top module: `dual_reg_xcvr`

## Requirements
- R1: When `isolate[s]` is 1, section s has `a_drv[s]`=0 and `b_drv[s]`=0, and its slices of `a_out` and `b_out` are all zero, whatever `dir_ab[s]` is.
- R2: When `isolate[s]` is 0, `dir_ab[s]`=1 sets `b_drv[s]`=1 and `a_drv[s]`=0, and `dir_ab[s]`=0 sets `a_drv[s]`=1 and `b_drv[s]`=0.
- R3: While B is driven and `sel_ab[s]`=0, the B slice of section s equals its A input slice in the same cycle, with no register in the path.
- R4: While B is driven and `sel_ab[s]`=1, the B slice equals the A-side stored register, and changes on the A input have no effect on it.
- R5: The A output mirrors R3 and R4 using `sel_ba[s]`: 0 gives the live B input slice, and 1 gives the B-side stored register.
- R6: A register loads its bus input slice at a clock edge where its strobe is 1 and was 0 at the previous edge. The new value is visible right after that edge. Holding the strobe at 1 loads nothing more.
- R7: Loading ignores `isolate` and `dir_ab`. Both registers of a section can load at the same edge while both buses are isolated.
- R8: While a strobe stays low, its register keeps its contents, whatever its bus input does.
- R9: A low `rst_n` at a clock edge (synchronous, active low) clears both registers to zero. It also records each strobe as already high, so a strobe that is still high when reset ends does not count as a rising edge.
- R10: While a port drives, the value on its own input is what that side's register loads (loopback capture).
- R11: Each section responds only to its own control bits. Section s uses bits [s*WIDTH +: WIDTH] of every data port and bit s of every control and flag port.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; strobes are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| isolate | input | NSEC | Per section: 1 releases both buses |
| dir_ab | input | NSEC | Per section: 1 drives B from A, 0 drives A from B |
| cap_ab | input | NSEC | Per section: capture strobe for the A-side register |
| cap_ba | input | NSEC | Per section: capture strobe for the B-side register |
| sel_ab | input | NSEC | Per section: source for B, 0 live A, 1 stored A |
| sel_ba | input | NSEC | Per section: source for A, 0 live B, 1 stored B |
| a_in | input | NSEC*WIDTH | Value seen on bus A |
| b_in | input | NSEC*WIDTH | Value seen on bus B |
| a_out | output | NSEC*WIDTH | Value driven onto bus A (zero when not driven) |
| a_drv | output | NSEC | Per section: bus A is driven |
| b_out | output | NSEC*WIDTH | Value driven onto bus B (zero when not driven) |
| b_drv | output | NSEC | Per section: bus B is driven |

## Verification
Two functions can act in the same cycle: a register load, and either the stored-mode readout of that register or the driving of the bus that feeds it. The bench provokes both. It raises both strobes at the same edge while the buses are isolated, then reads both registers back in stored mode. It also loads a side's register while that side is driving and its input carries the driven value. A reference model of the function table, updated at every edge, computes the result after each edge: the new stored value, or the loopback value. A long random run with different controls in the two sections is compared against the same model.

// File: rtl/xcvr_pkg.sv
// Shared encodings for the registered bus transceiver.
// Assumes: single-bit select and direction controls.
package xcvr_pkg;
    typedef enum logic {
        SRC_LIVE   = 1'b0,
        SRC_STORED = 1'b1
    } src_sel_e;

    typedef enum logic {
        DIR_B_TO_A = 1'b0,
        DIR_A_TO_B = 1'b1
    } xfer_dir_e;
endpackage

// File: rtl/xcvr_rise_det.sv
// Rising-edge detector for a capture strobe sampled on clk.
// Assumes: strobe is synchronous to clk. After reset the strobe history
// reads high, so a strobe already high is not an edge.
module xcvr_rise_det (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    output logic rise
);
    logic hist_q;

    // Remember the strobe level seen at the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) hist_q <= 1'b1;
        else        hist_q <= strobe;
    end

    assign rise = strobe & ~hist_q;

    // A held strobe yields one edge only.
    assert_single_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise)
        else $error("strobe edge reported twice in a row");
endmodule

// File: rtl/xcvr_store.sv
// One storage register of a transceiver section, loaded on a strobe rise.
// Assumes: d is the value observed on the bus feeding this register.
module xcvr_store #(
    parameter int WIDTH = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic rise;

    xcvr_rise_det u_rise (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (strobe),
        .rise   (rise)
    );

    // Load the bus value on a strobe rise, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (rise) q <= d;
    end

    assert_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> q == $past(d))
        else $error("register missed its load");

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rise |=> $stable(q))
        else $error("register changed without a strobe edge");

    assert_reset_clear_R9: assert property (@(posedge clk)
        !rst_n |=> q == '0)
        else $error("register not cleared by reset");
endmodule

// File: rtl/xcvr_section.sv
// One transceiver section: two stores, two source muxes, drive control.
// Assumes: outputs are combinational from controls, inputs and stores;
// an undriven output is forced to zero.
module xcvr_section
    import xcvr_pkg::*;
#(
    parameter int WIDTH = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             isolate,
    input  logic             dir_ab,
    input  logic             cap_ab,
    input  logic             cap_ba,
    input  logic             sel_ab,
    input  logic             sel_ba,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] a_out,
    output logic             a_drv,
    output logic [WIDTH-1:0] b_out,
    output logic             b_drv
);
    logic [WIDTH-1:0] stored_a;
    logic [WIDTH-1:0] stored_b;
    xfer_dir_e        dir;
    src_sel_e         src_b;
    src_sel_e         src_a;

    xcvr_store #(.WIDTH(WIDTH)) u_store_a (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (cap_ab),
        .d      (a_in),
        .q      (stored_a)
    );

    xcvr_store #(.WIDTH(WIDTH)) u_store_b (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (cap_ba),
        .d      (b_in),
        .q      (stored_b)
    );

    // Decode the drive side of this section.
    always_comb begin
        dir   = xfer_dir_e'(dir_ab);
        b_drv = !isolate && (dir == DIR_A_TO_B);
        a_drv = !isolate && (dir == DIR_B_TO_A);
    end

    // Pick live or stored data for each driven bus.
    always_comb begin
        src_b = src_sel_e'(sel_ab);
        src_a = src_sel_e'(sel_ba);
        b_out = '0;
        a_out = '0;
        if (b_drv) b_out = (src_b == SRC_STORED) ? stored_a : a_in;
        if (a_drv) a_out = (src_a == SRC_STORED) ? stored_b : b_in;
    end

    assert_isolated_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        isolate |-> (!a_drv && !b_drv && a_out == '0 && b_out == '0))
        else $error("isolated section still drives");

    assert_one_side_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !isolate |-> (a_drv != b_drv))
        else $error("enabled section must drive exactly one bus");

    assert_live_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (b_drv && !sel_ab) |-> b_out == a_in)
        else $error("live A data not on B");

    assert_stored_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (b_drv && sel_ab) |-> b_out == stored_a)
        else $error("stored A data not on B");

    assert_mirror_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
        a_drv |-> a_out == (sel_ba ? stored_b : b_in))
        else $error("A output source wrong");
endmodule

// File: rtl/dual_reg_xcvr.sv
// Multi-section registered bidirectional bus transceiver.
// Assumes: each section owns one bit of every control port and one
// WIDTH-bit slice of every data port; sections share only clk and rst_n.
module dual_reg_xcvr #(
    parameter int NSEC  = 2,
    parameter int WIDTH = 9
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NSEC-1:0]       isolate,
    input  logic [NSEC-1:0]       dir_ab,
    input  logic [NSEC-1:0]       cap_ab,
    input  logic [NSEC-1:0]       cap_ba,
    input  logic [NSEC-1:0]       sel_ab,
    input  logic [NSEC-1:0]       sel_ba,
    input  logic [NSEC*WIDTH-1:0] a_in,
    input  logic [NSEC*WIDTH-1:0] b_in,
    output logic [NSEC*WIDTH-1:0] a_out,
    output logic [NSEC-1:0]       a_drv,
    output logic [NSEC*WIDTH-1:0] b_out,
    output logic [NSEC-1:0]       b_drv
);
    // One independent section per slice (R11).
    for (genvar s = 0; s < NSEC; s++) begin : g_sec
        xcvr_section #(.WIDTH(WIDTH)) u_sec (
            .clk     (clk),
            .rst_n   (rst_n),
            .isolate (isolate[s]),
            .dir_ab  (dir_ab[s]),
            .cap_ab  (cap_ab[s]),
            .cap_ba  (cap_ba[s]),
            .sel_ab  (sel_ab[s]),
            .sel_ba  (sel_ba[s]),
            .a_in    (a_in[s*WIDTH +: WIDTH]),
            .b_in    (b_in[s*WIDTH +: WIDTH]),
            .a_out   (a_out[s*WIDTH +: WIDTH]),
            .a_drv   (a_drv[s]),
            .b_out   (b_out[s*WIDTH +: WIDTH]),
            .b_drv   (b_drv[s])
        );
    end
endmodule

// File: tb/tb_dual_reg_xcvr.sv
// Scoreboard bench: the driver applies inputs after a falling edge and queues
// the model's expected outputs; the monitor checks them after the next rising edge.
module tb_dual_reg_xcvr;
    localparam int NS = 2;
    localparam int W  = 9;

    typedef struct packed {
        logic [NS*W-1:0] a;
        logic [NS*W-1:0] b;
        logic [NS-1:0]   ad;
        logic [NS-1:0]   bd;
    } exp_t;

    logic clk = 1'b0;
    logic rstn;
    logic [NS-1:0] iso, dir, cab, cba, sab, sba;
    logic [W-1:0]  ain [NS];
    logic [W-1:0]  bin [NS];
    logic [NS*W-1:0] a_in, b_in, a_out, b_out;
    logic [NS-1:0]   a_drv, b_drv;

    logic [W-1:0] ma [NS];
    logic [W-1:0] mb [NS];
    logic [NS-1:0] pa, pb;

    exp_t  q_exp[$];
    string q_tag[$];
    int    errors = 0;
    int    checks = 0;
    bit    done   = 0;

    always #4 clk = ~clk;

    assign a_in = {ain[1], ain[0]};
    assign b_in = {bin[1], bin[0]};

    dual_reg_xcvr #(.NSEC(NS), .WIDTH(W)) dut (
        .clk (clk), .rst_n (rstn), .isolate (iso), .dir_ab (dir),
        .cap_ab (cab), .cap_ba (cba), .sel_ab (sab), .sel_ba (sba),
        .a_in (a_in), .b_in (b_in), .a_out (a_out), .a_drv (a_drv),
        .b_out (b_out), .b_drv (b_drv)
    );

    // Update the reference model for the coming edge, queue the result, wait.
    task automatic step(input string tag);
        exp_t e;
        for (int s = 0; s < NS; s++) begin
            if (!rstn) begin
                ma[s] = '0; mb[s] = '0; pa[s] = 1'b1; pb[s] = 1'b1;
            end else begin
                if (cab[s] && !pa[s]) ma[s] = ain[s];
                if (cba[s] && !pb[s]) mb[s] = bin[s];
                pa[s] = cab[s];
                pb[s] = cba[s];
            end
            e.bd[s] = !iso[s] && dir[s];
            e.ad[s] = !iso[s] && !dir[s];
            e.b[s*W +: W] = e.bd[s] ? (sab[s] ? ma[s] : ain[s]) : '0;
            e.a[s*W +: W] = e.ad[s] ? (sba[s] ? mb[s] : bin[s]) : '0;
        end
        q_exp.push_back(e);
        q_tag.push_back(tag);
        @(negedge clk);
    endtask

    // Monitor: compare after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q_exp.size() > 0) begin
                exp_t  e;
                exp_t  g;
                string t;
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                g = '{a: a_out, b: b_out, ad: a_drv, bd: b_drv};
                checks++;
                if (g !== e) begin
                    errors++;
                    $display("FAIL %s: got a=%h b=%h ad=%b bd=%b expected a=%h b=%h ad=%b bd=%b",
                             t, g.a, g.b, g.ad, g.bd, e.a, e.b, e.ad, e.bd);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #(200000 * 8);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rstn = 1'b0; iso = '1; dir = '0; cab = '1; cba = '0; sab = '0; sba = '0;
        for (int s = 0; s < NS; s++) begin ain[s] = 9'h1FF; bin[s] = 9'h0F3; end
        // R9: reset, strobe A held high across release
        step("R9 reset"); step("R9 reset");
        rstn = 1'b1; iso = '0; dir = '1; sab = '1;
        step("R9 held strobe is no edge");
        step("R9 stored still zero");
        // R1: isolation ignores direction
        iso = '1; cab = '0;
        step("R1 isolate dir=1");
        dir = '0; step("R1 isolate dir=0");
        // R2 / R3: live A to B
        iso = '0; dir = '1; sab = '0; ain[0] = 9'h0A5;
        step("R2 R3 live A to B");
        ain[0] = 9'h15A; step("R3 live follows input");
        dir[0] = 1'b0; sba[0] = 1'b0; step("R2 R5 live B to A");
        // R6: rising strobe loads, held strobe does not reload
        dir[0] = 1'b1; sab[0] = 1'b1; cab[0] = 1'b1; ain[0] = 9'h123;
        step("R6 load on rise");
        ain[0] = 9'h0F0; step("R6 held strobe no reload");
        // R4: stored path ignores live A
        cab[0] = 1'b0; ain[0] = 9'h00F; step("R4 stored A on B");
        // R7: simultaneous loads while isolated
        iso[0] = 1'b1; ain[0] = 9'h055; bin[0] = 9'h1AA; cab[0] = 1'b1; cba[0] = 1'b1;
        step("R7 both load while isolated");
        cab[0] = 1'b0; cba[0] = 1'b0; iso[0] = 1'b0; dir[0] = 1'b1;
        step("R7 stored A readback");
        dir[0] = 1'b0; sba[0] = 1'b1; step("R7 R5 stored B readback");
        // R8: no strobe, inputs move, contents hold
        ain[0] = 9'h111; bin[0] = 9'h022; step("R8 hold B side");
        dir[0] = 1'b1; step("R8 hold A side");
        // R10: B driven from live A; B input carries the driven value; load B
        sab[0] = 1'b0; ain[0] = 9'h16C; bin[0] = 9'h16C; cba[0] = 1'b1;
        step("R10 loopback load");
        cba[0] = 1'b0; dir[0] = 1'b0; sba[0] = 1'b1; bin[0] = 9'h000; ain[0] = 9'h001;
        step("R10 loopback value stored");
        // R11: independent random controls per section
        for (int i = 0; i < 600; i++) begin
            iso = NS'($urandom); dir = NS'($urandom);
            cab = NS'($urandom); cba = NS'($urandom);
            sab = NS'($urandom); sba = NS'($urandom);
            for (int s = 0; s < NS; s++) begin
                ain[s] = W'($urandom); bin[s] = W'($urandom);
            end
            step("R11 random sections");
        end
        @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule